// File: doc/BRIEF.md
# Aligned Window Splitter for Address Regions

This block takes one address region, described by a physical start, a bus start and a byte count, and cuts it into a run of naturally aligned power-of-two windows. Each window goes out as one record: a slot index, a match address, a remap address, a mask and an enable bit. A window-bank programming engine consumes the records over a valid/ready handshake. At each step the window is as large as the remaining size and the alignment of the physical start both allow. After the window is accepted, the physical start, the bus start, the remaining size and the slot index all move on.

Splitting ends in one of three ways. The region is fully covered. The slot bank runs out. Or a window would be smaller than the floor, or would need bus-address bits that the mask leaves free. The second and third endings report an error and return an invalid slot index. The caller supplies the first free slot with each region, so several regions can be packed one after another. Passing an invalid index makes the unit refuse the region. A sweep option makes the unit then issue disable records for every slot that is left. After an error, the sweep covers every slot.

Top module: `winsplit_region`

## Requirements
- R1: Each window size is the lower of two values: the highest power of two not above the remaining size, and the lowest set bit of the current physical start. A physical start of zero sets no alignment limit.
- R2: Each enabled record carries en=1, match equal to the current physical start, remap equal to the current bus start, and mask equal to the bitwise inverse of (window size minus one), over ADDR_W bits.
- R3: If the window size would be below 2^MIN_SHIFT (0x10000 by default), or the bus start has a bit set below the window size, no record is emitted for it. Splitting then ends with err_o=1.
- R4: After each accepted record, the physical start and the bus start both grow by the window size, the remaining size shrinks by it, and the slot index rises by one. win_idx_o equals that slot index.
- R5: No enabled record is emitted for a slot index at or above NUM_WIN (8). If size remains when the slots run out, the run ends with err_o=1.
- R6: A start slot index of all ones (the invalid value, 31 with the defaults) makes the unit emit no enabled record and end with err_o=1.
- R7: When the size reaches zero without a failure, the run ends with err_o=0. next_idx_o then holds the first unused slot index. A zero-size region emits nothing and returns its start index.
- R8: While win_valid_o is high and win_ready_i is low, win_valid_o stays high and every record field holds its value.
- R9: With sweep_i set at start, the unit emits, after splitting ends, one record for each slot from next_idx_o up to NUM_WIN-1, in ascending order. After an error the sweep starts at slot 0. Each of these records has en=0 and zero match, remap and mask.
- R10: done_o pulses high for exactly one cycle at the end of a run. At that cycle err_o and next_idx_o are final, and next_idx_o is all ones whenever err_o is 1. busy_o is high from the cycle after start_i until done_o, and low again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; sampled only while idle |
| phys_i | input | ADDR_W | Physical start of the region |
| bus_i | input | ADDR_W | Bus start of the region |
| size_i | input | ADDR_W | Region size in bytes |
| first_idx_i | input | IDX_W | First free slot; all ones means invalid |
| sweep_i | input | 1 | Issue disable records for the unused slots after splitting |
| win_valid_o | output | 1 | A record is presented |
| win_ready_i | input | 1 | Consumer accepts the record |
| win_idx_o | output | SLOT_W | Slot index of the record |
| win_en_o | output | 1 | 1 for a programmed window, 0 for a disable record |
| win_match_o | output | ADDR_W | Match (physical) address |
| win_remap_o | output | ADDR_W | Remap (bus) address |
| win_mask_o | output | ADDR_W | Address mask |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run left size uncovered or was refused |
| next_idx_o | output | IDX_W | Next free slot after the last run; all ones after an error |

## Verification
A wrong remaining size or a wrong physical start shows up in the very next record as a mismatched match address or mask. It also changes the number of records emitted before done_o. A wrong slot counter shows up as the wrong win_idx_o on the second record, and as the wrong next_idx_o at done_o. A wrong termination decision shows up as a missing or extra record, or as the wrong err_o, in the cycle where done_o pulses. During a sweep, a bad sweep start appears in the index of the first disable record.

// File: rtl/winsplit_pkg.sv
package winsplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SWEEP = 2'd2,
        ST_FIN   = 2'd3
    } split_state_e;

endpackage

// File: rtl/winsplit_msb.sv
// Isolates the highest set bit of a vector and flags a non-zero vector.
module winsplit_msb #(
    parameter int W = 40
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] top_o,
    output logic         any_o
);
    logic [W:0] seen;

    assign seen[W] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_scan
        assign top_o[i] = vec_i[i] & ~seen[i+1];
        assign seen[i]  = seen[i+1] | vec_i[i];
    end

    assign any_o = seen[0];
endmodule

// File: rtl/winsplit_lsb.sv
// Isolates the lowest set bit of a vector (zero stays zero).
module winsplit_lsb #(
    parameter int W = 40
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] low_o
);
    assign low_o = vec_i & (~vec_i + {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/winsplit_step.sv
// One splitting step: window size, mask and the two stop conditions.
module winsplit_step #(
    parameter int W         = 40,
    parameter int MIN_SHIFT = 16
) (
    input  logic [W-1:0] size_i,
    input  logic [W-1:0] phys_i,
    input  logic [W-1:0] bus_i,
    output logic [W-1:0] win_o,
    output logic [W-1:0] mask_o,
    output logic         small_o,
    output logic         misalign_o,
    output logic         nonzero_o
);
    logic [W-1:0] size_top;
    logic [W-1:0] phys_low;
    logic [W-1:0] cand;

    winsplit_msb #(.W(W)) u_size_top (
        .vec_i (size_i),
        .top_o (size_top),
        .any_o (nonzero_o)
    );

    winsplit_lsb #(.W(W)) u_phys_low (
        .vec_i (phys_i),
        .low_o (phys_low)
    );

    // A zero start isolates to zero, so it adds no alignment bound.
    assign cand = size_top | phys_low;

    winsplit_lsb #(.W(W)) u_pick (
        .vec_i (cand),
        .low_o (win_o)
    );

    assign mask_o     = ~(win_o - {{(W-1){1'b0}}, 1'b1});
    assign small_o    = |win_o[MIN_SHIFT-1:0];
    assign misalign_o = |(bus_i & ~mask_o);
endmodule

// File: rtl/winsplit_region.sv
module winsplit_region
    import winsplit_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_WIN   = 8,
    parameter int MIN_SHIFT = 16,
    localparam int SLOT_W   = $clog2(NUM_WIN),
    localparam int SW_W     = $clog2(NUM_WIN + 1),
    localparam int IDX_W    = SW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] phys_i,
    input  logic [ADDR_W-1:0] bus_i,
    input  logic [ADDR_W-1:0] size_i,
    input  logic [IDX_W-1:0]  first_idx_i,
    input  logic              sweep_i,
    output logic              win_valid_o,
    input  logic              win_ready_i,
    output logic [SLOT_W-1:0] win_idx_o,
    output logic              win_en_o,
    output logic [ADDR_W-1:0] win_match_o,
    output logic [ADDR_W-1:0] win_remap_o,
    output logic [ADDR_W-1:0] win_mask_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [IDX_W-1:0]  next_idx_o
);
    localparam logic [IDX_W-1:0] SLOTS_I = IDX_W'(NUM_WIN);
    localparam logic [SW_W-1:0]  SLOTS_S = SW_W'(NUM_WIN);
    localparam logic [IDX_W-1:0] IDX_BAD = '1;

    typedef struct packed {
        split_state_e      st;
        logic [ADDR_W-1:0] phys;
        logic [ADDR_W-1:0] bus;
        logic [ADDR_W-1:0] size;
        logic [IDX_W-1:0]  idx;
        logic [SW_W-1:0]   sw;
        logic              sweep;
        logic              err;
    } split_regs_t;

    split_regs_t r_q, r_d;

    logic [ADDR_W-1:0] step_win;
    logic [ADDR_W-1:0] step_mask;
    logic              step_small;
    logic              step_misalign;
    logic              step_nonzero;

    winsplit_step #(.W(ADDR_W), .MIN_SHIFT(MIN_SHIFT)) u_step (
        .size_i     (r_q.size),
        .phys_i     (r_q.phys),
        .bus_i      (r_q.bus),
        .win_o      (step_win),
        .mask_o     (step_mask),
        .small_o    (step_small),
        .misalign_o (step_misalign),
        .nonzero_o  (step_nonzero)
    );

    logic idx_bad;
    logic idx_room;
    logic run_emit;
    logic sweep_emit;
    logic fin_now;
    logic fin_err;

    assign idx_bad    = (r_q.idx == IDX_BAD);
    assign idx_room   = (r_q.idx < SLOTS_I);
    assign run_emit   = (r_q.st == ST_RUN) && !idx_bad && step_nonzero &&
                        idx_room && !step_small && !step_misalign;
    assign sweep_emit = (r_q.st == ST_SWEEP) && (r_q.sw < SLOTS_S);

    // Run ends: invalid index or uncovered size are errors, zero size is not.
    assign fin_now = (r_q.st == ST_RUN) && !run_emit;
    assign fin_err = idx_bad || step_nonzero;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_RUN;
                    r_d.phys  = phys_i;
                    r_d.bus   = bus_i;
                    r_d.size  = size_i;
                    r_d.idx   = first_idx_i;
                    r_d.sweep = sweep_i;
                    r_d.err   = 1'b0;
                    r_d.sw    = '0;
                end
            end
            ST_RUN: begin
                if (fin_now) begin
                    r_d.err = fin_err;
                    if (fin_err) begin
                        r_d.idx = IDX_BAD;
                        r_d.sw  = '0;
                    end else if (r_q.idx >= SLOTS_I) begin
                        r_d.sw  = SLOTS_S;
                    end else begin
                        r_d.sw  = r_q.idx[SW_W-1:0];
                    end
                    r_d.st = r_q.sweep ? ST_SWEEP : ST_FIN;
                end else if (win_ready_i) begin
                    r_d.phys = r_q.phys + step_win;
                    r_d.bus  = r_q.bus + step_win;
                    r_d.size = r_q.size - step_win;
                    r_d.idx  = r_q.idx + 1'b1;
                end
            end
            ST_SWEEP: begin
                if (!sweep_emit) begin
                    r_d.st = ST_FIN;
                end else if (win_ready_i) begin
                    r_d.sw = r_q.sw + 1'b1;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, phys: '0, bus: '0, size: '0,
                     idx: '0, sw: '0, sweep: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign win_valid_o = run_emit || sweep_emit;
    assign win_en_o    = (r_q.st == ST_RUN);
    assign win_idx_o   = (r_q.st == ST_RUN) ? r_q.idx[SLOT_W-1:0] : r_q.sw[SLOT_W-1:0];
    assign win_match_o = (r_q.st == ST_RUN) ? r_q.phys : '0;
    assign win_remap_o = (r_q.st == ST_RUN) ? r_q.bus : '0;
    assign win_mask_o  = (r_q.st == ST_RUN) ? step_mask : '0;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_FIN);
    assign err_o       = r_q.err;
    assign next_idx_o  = r_q.idx;
endmodule

// File: rtl/winsplit_region_chk.sv
module winsplit_region_chk #(
    parameter int ADDR_W    = 40,
    parameter int MIN_SHIFT = 16,
    parameter int SLOT_W    = 3,
    parameter int IDX_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_valid_o,
    input logic              win_ready_i,
    input logic [SLOT_W-1:0] win_idx_o,
    input logic              win_en_o,
    input logic [ADDR_W-1:0] win_match_o,
    input logic [ADDR_W-1:0] win_remap_o,
    input logic [ADDR_W-1:0] win_mask_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [IDX_W-1:0]  next_idx_o
);
    AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o && !win_ready_i |=> win_valid_o && $stable(win_idx_o) &&
        $stable(win_en_o) && $stable(win_match_o) && $stable(win_remap_o) &&
        $stable(win_mask_o)); // R8

    AST_WINDOW_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o && win_en_o |-> ((win_match_o & ~win_mask_o) == '0) &&
        ((win_remap_o & ~win_mask_o) == '0) &&
        (win_mask_o[MIN_SHIFT-1:0] == '0)); // R3

    AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o && !win_en_o |-> (win_match_o == '0) &&
        (win_remap_o == '0) && (win_mask_o == '0)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R10

    AST_ERR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && err_o |-> next_idx_o == '1); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !win_valid_o); // R10
endmodule

bind winsplit_region winsplit_region_chk #(
    .ADDR_W    (ADDR_W),
    .MIN_SHIFT (MIN_SHIFT),
    .SLOT_W    (SLOT_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_valid_o (win_valid_o),
    .win_ready_i (win_ready_i),
    .win_idx_o   (win_idx_o),
    .win_en_o    (win_en_o),
    .win_match_o (win_match_o),
    .win_remap_o (win_remap_o),
    .win_mask_o  (win_mask_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .next_idx_o  (next_idx_o)
);

// File: tb/winsplit_region_bench.sv
module winsplit_region_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 40;
    localparam int IW         = 5;
    localparam int SW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] phys_i = '0;
    logic [AW-1:0] bus_i = '0;
    logic [AW-1:0] size_i = '0;
    logic [IW-1:0] first_idx_i = '0;
    logic          sweep_i = 1'b0;
    logic          win_valid_o;
    logic          win_ready_i = 1'b1;
    logic [SW-1:0] win_idx_o;
    logic          win_en_o;
    logic [AW-1:0] win_match_o;
    logic [AW-1:0] win_remap_o;
    logic [AW-1:0] win_mask_o;
    logic          busy_o;
    logic          done_o;
    logic          err_o;
    logic [IW-1:0] next_idx_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    winsplit_region u_winsplit_region (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .phys_i (phys_i), .bus_i (bus_i), .size_i (size_i),
        .first_idx_i (first_idx_i), .sweep_i (sweep_i),
        .win_valid_o (win_valid_o), .win_ready_i (win_ready_i),
        .win_idx_o (win_idx_o), .win_en_o (win_en_o),
        .win_match_o (win_match_o), .win_remap_o (win_remap_o),
        .win_mask_o (win_mask_o), .busy_o (busy_o), .done_o (done_o),
        .err_o (err_o), .next_idx_o (next_idx_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    int            g_n;
    logic [SW-1:0] g_idx   [16];
    logic          g_en    [16];
    logic [AW-1:0] g_match [16];
    logic [AW-1:0] g_remap [16];
    logic [AW-1:0] g_mask  [16];
    logic          g_err;
    logic [IW-1:0] g_next;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, what, act, exp);
    endtask

    // Launch a region and collect every accepted record until done_o.
    task automatic launch(input logic [AW-1:0] ph, input logic [AW-1:0] bu,
                          input logic [AW-1:0] sz, input logic [IW-1:0] fi,
                          input logic sw, input int hold);
        bit held = 0;
        g_n = 0;
        @(negedge clk);
        phys_i = ph; bus_i = bu; size_i = sz; first_idx_i = fi; sweep_i = sw;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (done_o) begin
                g_err  = err_o;
                g_next = next_idx_o;
                break;
            end
            if (win_valid_o && hold > 0 && !held) begin
                logic [AW-1:0] m0;
                logic [SW-1:0] i0;
                held = 1;
                win_ready_i = 1'b0;
                m0 = win_match_o;
                i0 = win_idx_o;
                for (int h = 0; h < hold; h++) begin
                    @(negedge clk);
                    chk(win_valid_o && win_match_o == m0 && win_idx_o == i0,
                        "R8", "record held under backpressure",
                        {24'd0, win_match_o}, {24'd0, m0});
                end
                win_ready_i = 1'b1;
            end
            if (win_valid_o && win_ready_i && g_n < 16) begin
                g_idx[g_n]   = win_idx_o;
                g_en[g_n]    = win_en_o;
                g_match[g_n] = win_match_o;
                g_remap[g_n] = win_remap_o;
                g_mask[g_n]  = win_mask_o;
                g_n++;
            end
            @(negedge clk);
        end
        // One cycle after done the pulse is gone and the unit is idle.
        @(negedge clk);
        chk(!done_o && !busy_o, "R10", "done is a single pulse then idle",
            {62'd0, done_o, busy_o}, 64'd0);
    endtask

    task automatic t_reset;
        chk(!win_valid_o && !busy_o && !done_o && !err_o, "R10", "reset state",
            {60'd0, win_valid_o, busy_o, done_o, err_o}, 64'd0);
    endtask

    task automatic t_two_windows;
        launch(40'h00_0002_0000, 40'h01_0002_0000, 40'h00_0003_0000, 5'd0, 1'b0, 0);
        chk_eq("R1", "window count", g_n, 2);
        chk_eq("R2", "first mask (128 KiB)", g_mask[0], 40'hFF_FFFE_0000);
        chk_eq("R2", "first match", g_match[0], 40'h00_0002_0000);
        chk_eq("R2", "first enable", g_en[0], 1);
        chk_eq("R4", "second match advanced", g_match[1], 40'h00_0004_0000);
        chk_eq("R4", "second remap advanced", g_remap[1], 40'h01_0004_0000);
        chk_eq("R1", "second mask (64 KiB)", g_mask[1], 40'hFF_FFFF_0000);
        chk_eq("R4", "second slot index", g_idx[1], 1);
        chk_eq("R7", "no error", g_err, 0);
        chk_eq("R7", "next free slot", g_next, 2);
    endtask

    task automatic t_zero_phys;
        launch(40'h0, 40'h0, 40'h01_0000_0000, 5'd3, 1'b0, 0);
        chk_eq("R1", "zero start one window", g_n, 1);
        chk_eq("R1", "4 GiB mask", g_mask[0], 40'hFF_0000_0000);
        chk_eq("R4", "slot index from start", g_idx[0], 3);
        chk_eq("R7", "next after zero start", g_next, 4);
    endtask

    task automatic t_bus_misalign;
        launch(40'h00_0010_0000, 40'h00_0010_8000, 40'h00_0010_0000, 5'd0, 1'b0, 0);
        chk_eq("R3", "misaligned bus emits nothing", g_n, 0);
        chk_eq("R3", "misaligned bus error", g_err, 1);
        chk_eq("R5", "error index invalid", g_next, 5'h1F);
    endtask

    task automatic t_floor;
        launch(40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0001_8000, 5'd0, 1'b0, 0);
        chk_eq("R3", "64 KiB then remainder below floor", g_n, 1);
        chk_eq("R3", "floor error", g_err, 1);
    endtask

    task automatic t_slots_full;
        launch(40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0004_0000, 5'd6, 1'b0, 0);
        chk_eq("R5", "only two slots left", g_n, 2);
        chk_eq("R5", "last slot index", g_idx[1], 7);
        chk_eq("R1", "second window 128 KiB", g_mask[1], 40'hFF_FFFE_0000);
        chk_eq("R5", "leftover error", g_err, 1);
        chk_eq("R5", "leftover invalid index", g_next, 5'h1F);
    endtask

    task automatic t_bad_index;
        launch(40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0001_0000, 5'h1F, 1'b0, 0);
        chk_eq("R6", "invalid index emits nothing", g_n, 0);
        chk_eq("R6", "invalid index error", g_err, 1);
    endtask

    task automatic t_zero_size;
        launch(40'h00_0001_0000, 40'h0, 40'h0, 5'd3, 1'b0, 0);
        chk_eq("R7", "zero size emits nothing", g_n, 0);
        chk_eq("R7", "zero size no error", g_err, 0);
        chk_eq("R7", "zero size keeps index", g_next, 3);
    endtask

    task automatic t_backpressure;
        launch(40'h00_0002_0000, 40'h00_0002_0000, 40'h00_0003_0000, 5'd0, 1'b0, 4);
        chk_eq("R8", "count after stall", g_n, 2);
        chk_eq("R8", "first record intact", g_match[0], 40'h00_0002_0000);
    endtask

    task automatic t_sweep_ok;
        launch(40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0001_0000, 5'd5, 1'b1, 0);
        chk_eq("R9", "one window plus two disables", g_n, 3);
        chk_eq("R9", "first disable slot", g_idx[1], 6);
        chk_eq("R9", "last disable slot", g_idx[2], 7);
        chk_eq("R9", "disable enable bit", g_en[2], 0);
        chk_eq("R9", "disable mask zero", g_mask[1], 0);
        chk_eq("R7", "next after sweep", g_next, 6);
    endtask

    task automatic t_sweep_err;
        launch(40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0000_8000, 5'd2, 1'b1, 0);
        chk_eq("R9", "error sweep covers all slots", g_n, 8);
        chk_eq("R9", "error sweep starts at 0", g_idx[0], 0);
        chk_eq("R9", "error sweep ends at 7", g_idx[7], 7);
        chk_eq("R9", "error sweep match zero", g_match[0], 0);
        chk_eq("R3", "error flagged", g_err, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_windows();
        t_zero_phys();
        t_bus_misalign();
        t_floor();
        t_slots_full();
        t_bad_index();
        t_zero_size();
        t_backpressure();
        t_sweep_ok();
        t_sweep_err();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule